// File: doc/BRIEF.md
# Auto-Reload Timer with Down-Count Option

This block is a 16-bit timer/counter paired with a 16-bit reload register. Each count step comes from one of two sources. In timer mode the source is an internal tick, one per twelve system clocks. In counter mode it is a falling edge on the external count pin. The count advances only while the run bit is set. With auto-reload enabled, the counter counts up from the reload value to FFFFh and is then reloaded. With the direction bit set, it instead counts down from FFFFh and is refilled with FFFFh when it reaches the reload value. With auto-reload off, it wraps between 0000h and FFFFh in either direction.

A falling edge on a separate external reload input can force an early reload from the reload register, provided that input is enabled. Every overflow or underflow sets a sticky overflow flag. Every accepted external reload sets a sticky external flag. The interrupt request is the OR of the two flags. In timer mode the count pin can be turned into an output that inverts its level on every overflow.

Software reaches the block through a byte-wide write port and a combinational read port. The registers are a control register, a mode register, the two count bytes and the two reload bytes. Both external inputs pass through two-stage synchronizers before their edges are detected.

Top module: `reload_timer16`

## Requirements
- R1: With auto-reload on (control bit 3) and counting up (mode bit 0 = 0), a count step taken at FFFFh loads the reload value and sets the overflow flag (control bit 4).
- R2: With the external-reload enable (control bit 2) set, a falling edge on `ext_rld_i` loads the reload value into the count and sets the external flag (control bit 5). With the enable clear, the edge has no effect on the count or the flag.
- R3: Counting up increments by one per step from whatever value the count holds. With auto-reload off, a step at FFFFh gives 0000h and sets the overflow flag.
- R4: Counting down (mode bit 0 = 1) decrements by one per step. With auto-reload on, a step taken while the count equals the reload value loads FFFFh and sets the overflow flag. With auto-reload off, a step at 0000h loads FFFFh and sets the overflow flag.
- R5: In timer mode with the output enable set (mode bit 1), `cnt_pin_oe` is 1 and `cnt_pin_o` inverts on every overflow event and at no other time.
- R6: In timer mode (control bit 1 = 0) with run set (control bit 0), the count steps once every 12 clocks. The first step falls 12 clocks after run takes effect. With run clear, the count holds.
- R7: In counter mode (control bit 1 = 1) with run set, each falling edge on `cnt_pin_i` gives exactly one count step. The step lands on the third rising clock edge after the pin changes.
- R8: In counter mode the output enable is ignored: `cnt_pin_oe` stays 0 and `cnt_pin_o` does not change, even across an overflow.
- R9: Both flags stay set until software writes 0 to them through the control register. A flag-setting event in the same cycle wins over a clearing write. `irq` is 1 whenever either flag is set.
- R10: The registers read back at address 0 (control), 1 (mode), 2 and 3 (count low and high), and 4 and 5 (reload low and high). Bits 7 to 2 of the mode register read 0, and other addresses read 0.
- R11: A count-byte write in the same cycle as an external reload or a count step sets that byte and keeps the other byte unchanged. The external flag is still set. An external reload wins over a count step in the same cycle, and no overflow is flagged for that step.
- R12: After reset, all registers, both flags and `cnt_pin_o` are 0. Reset is applied asynchronously and released two clocks after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_pin_i | input | 1 | Count pin input level (event source in counter mode) |
| cnt_pin_o | output | 1 | Toggle output level for the count pin |
| cnt_pin_oe | output | 1 | Drive enable for the count pin |
| ext_rld_i | input | 1 | External reload request, falling-edge active |
| irq | output | 1 | Interrupt request, OR of the two flags |

## Verification
On every cycle, the assertions check the reload-on-overflow rules in both directions, the early reload on a qualified external edge, count holding while stopped, the stickiness of the overflow flag, that the toggle output moves only when the overflow flag is set, that the output enable stays off in counter mode, and that the unused mode bits read 0. Other behaviours need the bench's scenarios. These are the twelve-clock tick spacing, the three-edge latency from a count-pin edge, the fact that a disabled external edge is ignored, how the flags are cleared, and the priority when a count write coincides with an external reload. The bench covers them by running a behavioural model alongside the design and comparing the read port, the pin outputs and the interrupt on every clock.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_CNTL = 3'd2,
    A_CNTH = 3'd3,
    A_RLDL = 3'd4,
    A_RLDH = 3'd5
  } rt_addr_e;

  // control register bit positions
  localparam int B_RUN  = 0;
  localparam int B_CTR  = 1;
  localparam int B_EXEN = 2;
  localparam int B_ARL  = 3;
  localparam int B_TF   = 4;
  localparam int B_EXF  = 5;
  // mode register bit positions
  localparam int B_DOWN = 0;
  localparam int B_OE   = 1;
endpackage

// File: rtl/rt_sync_fall.sv
module rt_sync_fall #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d[0] = d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
      always_comb sync_d[i] = sync_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/rt_prescale.sv
module rt_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    if (!en)              pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = en & (pre_q == LAST);
endmodule

// File: rtl/rt_regs.sv
module rt_regs
  import rt_pkg::*;
#(
  parameter int CW = 2*DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          run,
  output logic          ctr,
  output logic          exen,
  output logic          arl,
  output logic          down,
  output logic          oe,
  output logic [CW-1:0] rld
);
  logic          ctrl_we, mode_we, rl_we, rh_we;
  logic [3:0]    ctl_q, ctl_d;
  logic [1:0]    mode_q, mode_d;
  logic [CW-1:0] rld_q, rld_d;

  always_comb begin
    ctrl_we = wr_en & (wr_addr == A_CTRL);
    mode_we = wr_en & (wr_addr == A_MODE);
    rl_we   = wr_en & (wr_addr == A_RLDL);
    rh_we   = wr_en & (wr_addr == A_RLDH);
    ctl_d   = ctrl_we ? wr_data[3:0] : ctl_q;
    mode_d  = mode_we ? wr_data[1:0] : mode_q;
    rld_d   = rld_q;
    if (rl_we) rld_d[DW-1:0]  = wr_data;
    if (rh_we) rld_d[CW-1:DW] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mode_q <= '0;
      rld_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      mode_q <= mode_d;
      rld_q  <= rld_d;
    end
  end

  assign run  = ctl_q[B_RUN];
  assign ctr  = ctl_q[B_CTR];
  assign exen = ctl_q[B_EXEN];
  assign arl  = ctl_q[B_ARL];
  assign down = mode_q[B_DOWN];
  assign oe   = mode_q[B_OE];
  assign rld  = rld_q;
endmodule

// File: rtl/rt_core.sv
module rt_core
  import rt_pkg::*;
#(
  parameter int CW = 2*DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick,
  input  logic          ext_fall,
  input  logic          exen,
  input  logic          arl,
  input  logic          down,
  input  logic          oe_eff,
  input  logic [CW-1:0] rld,
  output logic [CW-1:0] cnt,
  output logic          tf,
  output logic          exf,
  output logic          tog
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tf_q, tf_d, exf_q, exf_d, tog_q, tog_d;
  logic          wl, wh, ctrl_we, ext_ld, ovf, at_end;

  always_comb begin
    wl      = wr_en & (wr_addr == A_CNTL);
    wh      = wr_en & (wr_addr == A_CNTH);
    ctrl_we = wr_en & (wr_addr == A_CTRL);
    ext_ld  = exen & ext_fall;
    at_end  = down ? (arl ? (cnt_q == rld) : (cnt_q == '0)) : (cnt_q == MAXV);
    cnt_d   = cnt_q;
    ovf     = 1'b0;
    if (wl || wh) begin
      if (wl) cnt_d[DW-1:0]  = wr_data;
      if (wh) cnt_d[CW-1:DW] = wr_data;
    end else if (ext_ld) begin
      cnt_d = rld;
    end else if (tick) begin
      if (at_end) begin
        ovf   = 1'b1;
        cnt_d = down ? MAXV : (arl ? rld : '0);
      end else begin
        cnt_d = down ? (cnt_q - 1'b1) : (cnt_q + 1'b1);
      end
    end
    tf_d  = (ctrl_we ? wr_data[B_TF]  : tf_q)  | ovf;
    exf_d = (ctrl_we ? wr_data[B_EXF] : exf_q) | ext_ld;
    tog_d = tog_q ^ (ovf & oe_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tf_q  <= 1'b0;
      exf_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tf_q  <= tf_d;
      exf_q <= exf_d;
      tog_q <= tog_d;
    end
  end

  assign cnt = cnt_q;
  assign tf  = tf_q;
  assign exf = exf_q;
  assign tog = tog_q;
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rt_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          cnt_pin_i,
  output logic          cnt_pin_o,
  output logic          cnt_pin_oe,
  input  logic          ext_rld_i,
  output logic          irq
);
  localparam int CW = 2*DW;

  logic [1:0]    rst_sq;
  logic          rst_q;
  logic          run, ctr, exen, arl, down, oe, oe_eff;
  logic [CW-1:0] rld, cnt;
  logic          tf, exf, tog;
  logic          cfall, efall, ptick, tick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_q = rst_sq[1];

  rt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .ctr(ctr), .exen(exen), .arl(arl), .down(down), .oe(oe), .rld(rld)
  );

  rt_sync_fall #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csync (
    .clk(clk), .rst_n(rst_q), .d(cnt_pin_i), .fall(cfall)
  );

  rt_sync_fall #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_esync (
    .clk(clk), .rst_n(rst_q), .d(ext_rld_i), .fall(efall)
  );

  rt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_q), .en(run & ~ctr), .tick(ptick)
  );

  assign tick   = run & (ctr ? cfall : ptick);
  assign oe_eff = oe & ~ctr;

  rt_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .ext_fall(efall), .exen(exen), .arl(arl), .down(down),
    .oe_eff(oe_eff), .rld(rld), .cnt(cnt), .tf(tf), .exf(exf), .tog(tog)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {2'b00, exf, tf, arl, exen, ctr, run};
      A_MODE:  rd_data = {6'b000000, oe, down};
      A_CNTL:  rd_data = cnt[DW-1:0];
      A_CNTH:  rd_data = cnt[CW-1:DW];
      A_RLDL:  rd_data = rld[DW-1:0];
      A_RLDH:  rd_data = rld[CW-1:DW];
      default: rd_data = '0;
    endcase
  end

  assign cnt_pin_o  = tog;
  assign cnt_pin_oe = oe_eff;
  assign irq        = tf | exf;
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
(
  input logic          clk,
  input logic          rst_q,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic [15:0]   cnt,
  input logic [15:0]   rld,
  input logic          tick,
  input logic          efall,
  input logic          run,
  input logic          ctr,
  input logic          exen,
  input logic          arl,
  input logic          down,
  input logic          tf,
  input logic          pin_o,
  input logic          pin_oe
);
  logic cnt_wr;
  assign cnt_wr = wr_en & ((wr_addr == A_CNTL) | (wr_addr == A_CNTH));

  AST_UP_RELOAD: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && !down && arl && cnt == 16'hFFFF && !cnt_wr && !(exen && efall))
    |=> (cnt == $past(rld) && tf)); // R1

  AST_EXT_RELOAD: assert property (@(posedge clk) disable iff (!rst_q)
    (exen && efall && !cnt_wr) |=> (cnt == $past(rld))); // R2

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_q)
    (tick && down && arl && cnt == rld && !cnt_wr && !(exen && efall))
    |=> (cnt == 16'hFFFF && tf)); // R4

  AST_TOGGLE_ON_OVF: assert property (@(posedge clk) disable iff (!rst_q)
    (pin_o != $past(pin_o)) |-> tf); // R5

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_q)
    (!run && !cnt_wr && !(exen && efall)) |=> $stable(cnt)); // R6

  AST_CTR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_q)
    ctr |-> !pin_oe); // R8

  AST_CTR_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_q)
    ctr |=> $stable(pin_o)); // R8

  AST_TF_STICKY: assert property (@(posedge clk) disable iff (!rst_q)
    (tf && !(wr_en && wr_addr == A_CTRL)) |=> tf); // R9

  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_addr == A_MODE) |-> (rd_data[7:2] == 6'd0)); // R10
endmodule

bind reload_timer16 rt_checker u_chk (
  .clk(clk), .rst_q(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt), .rld(rld),
  .tick(tick), .efall(efall), .run(run), .ctr(ctr), .exen(exen),
  .arl(arl), .down(down), .tf(tf), .pin_o(cnt_pin_o), .pin_oe(cnt_pin_oe)
);

// File: tb/sim_reload_timer16.sv
`timescale 1ns/1ps
module sim_reload_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       cnt_pin_i = 1'b1;
  logic       cnt_pin_o, cnt_pin_oe;
  logic       ext_rld_i = 1'b1;
  logic       irq;

  always #5 clk = ~clk;

  reload_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin_i(cnt_pin_i), .cnt_pin_o(cnt_pin_o),
    .cnt_pin_oe(cnt_pin_oe), .ext_rld_i(ext_rld_i), .irq(irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R12";

  // behavioural reference state
  int m_rst_cnt;
  int m_cnt, m_rld, m_pre;
  bit m_run, m_ctr, m_exen, m_arl, m_down, m_oe, m_tf, m_exf, m_tog;
  bit cq[$];
  bit eq[$];

  function automatic int mread(input int a);
    case (a)
      0: return {m_exf, m_tf, m_arl, m_exen, m_ctr, m_run};
      1: return {m_oe, m_down};
      2: return m_cnt & 255;
      3: return (m_cnt >> 8) & 255;
      4: return m_rld & 255;
      5: return (m_rld >> 8) & 255;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst_cnt = 0; m_cnt = 0; m_rld = 0; m_pre = 0;
      m_run = 0; m_ctr = 0; m_exen = 0; m_arl = 0; m_down = 0; m_oe = 0;
      m_tf = 0; m_exf = 0; m_tog = 0;
      cq = '{1, 1, 1};
      eq = '{1, 1, 1};
    end else if (m_rst_cnt < 2) begin
      m_rst_cnt++;
    end else begin
      bit cf, ef, stp, ovf, extev, cw;
      int nc;
      cf = cq[0] && !cq[1];
      ef = eq[0] && !eq[1];
      cq.push_back(cnt_pin_i); void'(cq.pop_front());
      eq.push_back(ext_rld_i); void'(eq.pop_front());
      stp = m_run && (m_ctr ? cf : (m_pre == 11));
      if (m_run && !m_ctr) m_pre = (m_pre == 11) ? 0 : m_pre + 1;
      else m_pre = 0;
      extev = m_exen && ef;
      cw = wr_en && (wr_addr == 2 || wr_addr == 3);
      ovf = 0;
      nc = m_cnt;
      if (cw) begin
        if (wr_addr == 2) nc = (m_cnt & 16'hFF00) | wr_data;
        else              nc = (m_cnt & 16'h00FF) | (int'(wr_data) << 8);
      end else if (extev) begin
        nc = m_rld;
      end else if (stp) begin
        if (!m_down) begin
          if (m_cnt == 65535) begin ovf = 1; nc = m_arl ? m_rld : 0; end
          else nc = m_cnt + 1;
        end else begin
          if ((m_arl && m_cnt == m_rld) || (!m_arl && m_cnt == 0)) begin ovf = 1; nc = 65535; end
          else nc = m_cnt - 1;
        end
      end
      if (ovf && m_oe && !m_ctr) m_tog = !m_tog;
      if (wr_en && wr_addr == 0) begin
        m_tf = wr_data[4]; m_exf = wr_data[5];
      end
      m_tf = m_tf | ovf;
      m_exf = m_exf | extev;
      if (wr_en && wr_addr == 0) begin
        m_run = wr_data[0]; m_ctr = wr_data[1]; m_exen = wr_data[2]; m_arl = wr_data[3];
      end
      if (wr_en && wr_addr == 1) begin m_down = wr_data[0]; m_oe = wr_data[1]; end
      if (wr_en && wr_addr == 4) m_rld = (m_rld & 16'hFF00) | wr_data;
      if (wr_en && wr_addr == 5) m_rld = (m_rld & 16'h00FF) | (int'(wr_data) << 8);
      m_cnt = nc;
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      cmp($sformatf("rd_data[%0d]", rd_addr), rd_data, mread(rd_addr));
      cmp("irq", irq, m_tf | m_exf);
      cmp("cnt_pin_o", cnt_pin_o, m_tog);
      cmp("cnt_pin_oe", cnt_pin_oe, m_oe & !m_ctr);
    end
  end

  // read address rotates over all registers and one unused address
  always @(negedge clk) rd_addr <= (rd_addr >= 3'd6) ? 3'd0 : rd_addr + 3'd1;

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cnt();
    @(negedge clk); cnt_pin_i = 1'b0;
    idle(3);
    cnt_pin_i = 1'b1;
    idle(3);
  endtask

  task automatic pulse_ext();
    @(negedge clk); ext_rld_i = 1'b0;
    idle(3);
    ext_rld_i = 1'b1;
    idle(3);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      done = 1;
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R12";
    idle(10);

    cur_req = "R10";
    wr(3'd1, 8'hFF); idle(8);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'hA5); wr(3'd5, 8'h3C); idle(8);

    cur_req = "R6";
    wr(3'd2, 8'h10); wr(3'd3, 8'h00);
    wr(3'd0, 8'h01); idle(50);
    wr(3'd0, 8'h00); idle(30);

    cur_req = "R1";
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h09); idle(70);

    cur_req = "R9";
    wr(3'd0, 8'h08); idle(6);
    wr(3'd0, 8'h00); idle(6);

    cur_req = "R3";
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h01); idle(40);
    wr(3'd0, 8'h00);

    cur_req = "R4";
    wr(3'd1, 8'h01);
    wr(3'd4, 8'hFD); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h09); idle(60);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h01); wr(3'd3, 8'h00);
    wr(3'd0, 8'h01); idle(40);
    wr(3'd0, 8'h00);

    cur_req = "R5";
    wr(3'd1, 8'h02);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h09); idle(80);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    cur_req = "R7";
    wr(3'd2, 8'hF0); wr(3'd3, 8'h00);
    wr(3'd0, 8'h03);
    for (int i = 0; i < 4; i++) pulse_cnt();
    wr(3'd0, 8'h02);
    pulse_cnt();

    cur_req = "R8";
    wr(3'd1, 8'h02);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h03);
    for (int i = 0; i < 3; i++) pulse_cnt();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    cur_req = "R2";
    wr(3'd4, 8'h78); wr(3'd5, 8'h56);
    wr(3'd0, 8'h04);
    pulse_ext();
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h11);
    pulse_ext();
    idle(4);

    cur_req = "R11";
    wr(3'd0, 8'h04);
    @(negedge clk); ext_rld_i = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h55;
    @(negedge clk); wr_en = 1'b0;
    ext_rld_i = 1'b1;
    idle(6);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h05);
    @(negedge clk); ext_rld_i = 1'b0;
    idle(30);
    ext_rld_i = 1'b1;
    idle(6);
    wr(3'd0, 8'h00);

    cur_req = "R12";
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(12);

    done = 1;
    report();
  end
endmodule